// File: doc/BRIEF.md
# External Bus Chip-Select Cycle Controller

This block turns single read and write requests from an internal port into timed cycles on an external asynchronous memory bus. It holds six programmable address windows. Each request address is compared with all of them, and the first matching window supplies the timing for that cycle: setup cycles before its chip select asserts, wait states in the data phase, how the data phase ends (internal count or an external acknowledge pin), and how long the address is held after the chip select drops.

Software programs the windows through a write-only configuration port. Each window has three words: a base word, a mask word and a timing word. The internal side sees a valid/ready request port and a one-cycle response pulse that carries read data and an error flag. Only one bus cycle runs at a time.

Top module: `ebus_csctl`

## Requirements
- R1: After reset every chip select, output enable and write enable is high (inactive), `bus_aoe` and `rsp_valid` are low, `req_ready` is high, and all windows are invalid, so any request gets an error response.
- R2: A configuration write with `cfg_sel`=0 loads the window base from `cfg_wdata[31:16]`. With `cfg_sel`=1 it loads the compare mask from [31:16], write-protect from [8] and valid from [0]. With `cfg_sel`=2 it loads the timing word: secondary count [31:26], secondary enable [23], setup [21:20], read hold [19:18], write hold [17:16], wait count [15:10], auto-acknowledge [8]. `cfg_sel`=3 and window indices 6 and 7 change nothing.
- R3: A window matches when it is valid and `req_addr[31:16]` equals its base in every bit whose mask bit is 0. When several windows match, the lowest-numbered one drives its chip select. Only one chip select is ever low.
- R4: A request that matches no window, or a write that matches a write-protected window, gets `rsp_valid` with `rsp_err`=1 in the cycle after acceptance. It causes no bus activity. Reads of a protected window run normally.
- R5: After acceptance the address is driven with `bus_aoe` high. The chip select stays high for exactly setup (0..3) cycles before it asserts. The address is stable until `bus_aoe` falls.
- R6: With auto-acknowledge set, the chip select stays low for wait count + 1 cycles. During that time `bus_oe_n` is low on reads. On writes `bus_we_n` is low and `bus_dout` carries the write data. The two strobes are never low together.
- R7: With auto-acknowledge clear, the data phase ends at the first edge where the wait count has elapsed and `bus_ta_n` is low. Read data is captured from `bus_din` on that edge and returned in `rsp_rdata`.
- R8: With secondary enable set, a cycle to the same window as the previous completed bus cycle uses the secondary count instead of the wait count.
- R9: After a write's data phase, the address stays driven with chip select high for write hold + 1 cycles.
- R10: After a read's data phase, the address hold lasts read hold cycles when auto-acknowledge is set, and read hold + 1 cycles when it is clear.
- R11: `req_ready` is low from the acceptance edge until the response. `rsp_valid` is a single-cycle pulse that appears in the cycle after the last hold cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win | input | 3 | Window index for configuration write |
| cfg_sel | input | 2 | Word select: 0 base, 1 mask, 2 timing |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | 32 | Request address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was refused |
| rsp_rdata | output | 32 | Read data of the last read |
| bus_addr | output | 32 | External address |
| bus_aoe | output | 1 | External address is driven |
| bus_dout | output | 32 | External write data |
| bus_din | input | 32 | External read data |
| bus_cs_n | output | 6 | Active-low chip select per window |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_we_n | output | 1 | Active-low write enable |
| bus_ta_n | input | 1 | Active-low external transfer acknowledge |

## Verification
A wrong phase counter shows at once as a setup, data or hold phase of the wrong length. The bench counts every phase cycle by cycle at the bus pins, so a counter that is off by one is caught in the same transaction. A wrong latched window index or a broken priority drives the wrong chip select in the first data cycle. A stale "previous window" record shows up only in the transaction that follows, as a data phase of the primary length where the secondary length was due, or the reverse. A sequencer stuck outside idle holds `req_ready` low, and the next request then never completes.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    localparam int CFG_W = 32;
    localparam int CMP_W = 16;

    // configuration word field positions
    localparam int P_HI    = 16;
    localparam int P_VALID = 0;
    localparam int P_WPROT = 8;
    localparam int P_AA    = 8;
    localparam int P_WS    = 10;
    localparam int P_WRAH  = 16;
    localparam int P_RDAH  = 18;
    localparam int P_ASET  = 20;
    localparam int P_SWSEN = 23;
    localparam int P_SWS   = 26;

    typedef struct packed {
        logic [5:0] sws;
        logic       swsen;
        logic [1:0] aset;
        logic [1:0] rdah;
        logic [1:0] wrah;
        logic [5:0] ws;
        logic       aa;
    } tim_t;

    typedef struct packed {
        logic [CMP_W-1:0] base;
        logic [CMP_W-1:0] bmask;
        logic             valid;
        logic             wprot;
        tim_t             tim;
    } win_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_DATA  = 2'd2,
        ST_HOLD  = 2'd3
    } bus_st_t;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_CTRL = 2'd2
    } cfg_sel_t;

endpackage

// File: rtl/ebus_regs.sv
module ebus_regs
    import ebus_pkg::*;
#(
    parameter int NWIN = 6,
    localparam int IW = $clog2(NWIN)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [IW-1:0]         cfg_win,
    input  logic [1:0]            cfg_sel,
    input  logic [CFG_W-1:0]      cfg_wdata,
    output win_cfg_t [NWIN-1:0]   win_cfg
);

    logic cfg_unused;
    assign cfg_unused = ^{cfg_wdata[25:24], cfg_wdata[22], cfg_wdata[9], cfg_wdata[7:1]};

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        win_cfg_t w_d, w_q;
        logic     wr_hit;

        assign wr_hit = cfg_we && (cfg_win == IW'(i));

        always_comb begin
            w_d = w_q;
            if (wr_hit) begin
                case (cfg_sel)
                    SEL_BASE: w_d.base = cfg_wdata[P_HI +: CMP_W];
                    SEL_MASK: begin
                        w_d.bmask = cfg_wdata[P_HI +: CMP_W];
                        w_d.wprot = cfg_wdata[P_WPROT];
                        w_d.valid = cfg_wdata[P_VALID];
                    end
                    SEL_CTRL: begin
                        w_d.tim.sws   = cfg_wdata[P_SWS +: 6];
                        w_d.tim.swsen = cfg_wdata[P_SWSEN];
                        w_d.tim.aset  = cfg_wdata[P_ASET +: 2];
                        w_d.tim.rdah  = cfg_wdata[P_RDAH +: 2];
                        w_d.tim.wrah  = cfg_wdata[P_WRAH +: 2];
                        w_d.tim.ws    = cfg_wdata[P_WS +: 6];
                        w_d.tim.aa    = cfg_wdata[P_AA];
                    end
                    default: ;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) w_q <= '0;
            else        w_q <= w_d;
        end

        assign win_cfg[i] = w_q;
    end

endmodule

// File: rtl/ebus_decode.sv
module ebus_decode
    import ebus_pkg::*;
#(
    parameter int NWIN = 6,
    localparam int IW = $clog2(NWIN)
) (
    input  win_cfg_t [NWIN-1:0] win_cfg,
    input  logic [CMP_W-1:0]    addr_hi,
    output logic                hit,
    output logic [IW-1:0]       hit_idx,
    output logic                hit_wprot,
    output tim_t                hit_tim
);

    logic [NWIN-1:0] match;

    for (genvar i = 0; i < NWIN; i++) begin : g_match
        assign match[i] = win_cfg[i].valid &&
                          (((addr_hi ^ win_cfg[i].base) & ~win_cfg[i].bmask) == '0);
    end

    // walk from the top so the lowest matching index is the one left standing
    always_comb begin
        hit       = 1'b0;
        hit_idx   = '0;
        hit_wprot = 1'b0;
        hit_tim   = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit       = 1'b1;
                hit_idx   = IW'(i);
                hit_wprot = win_cfg[i].wprot;
                hit_tim   = win_cfg[i].tim;
            end
        end
    end

endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
    import ebus_pkg::*;
#(
    parameter int NWIN = 6,
    parameter int AW   = 32,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NWIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_we,
    input  logic [DW-1:0]     req_wdata,
    input  logic              dec_hit,
    input  logic [IW-1:0]     dec_idx,
    input  logic              dec_wprot,
    input  tim_t              dec_tim,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DW-1:0]     rsp_rdata,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_aoe,
    output logic [DW-1:0]     bus_dout,
    input  logic [DW-1:0]     bus_din,
    output logic [NWIN-1:0]   bus_cs_n,
    output logic              bus_oe_n,
    output logic              bus_we_n,
    input  logic              bus_ta_n
);

    typedef struct packed {
        bus_st_t       st;
        logic [5:0]    cnt;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [IW-1:0] widx;
        tim_t          tim;
        logic [DW-1:0] rdata;
        logic          rsp_v;
        logic          rsp_e;
        logic          last_v;
        logic [IW-1:0] last_i;
    } seq_t;

    seq_t d, q;

    function automatic logic [5:0] wait_of(input tim_t t, input logic same);
        return (t.swsen && same) ? t.sws : t.ws;
    endfunction

    function automatic logic [2:0] hold_of(input tim_t t, input logic wr);
        if (wr)        return {1'b0, t.wrah} + 3'd1;
        else if (t.aa) return {1'b0, t.rdah};
        else           return {1'b0, t.rdah} + 3'd1;
    endfunction

    logic       refuse;
    logic       same_new;
    logic       same_cur;
    logic       data_ack;
    logic [2:0] hold_len;

    assign refuse   = !dec_hit || (req_we && dec_wprot);
    assign same_new = q.last_v && (q.last_i == dec_idx);
    assign same_cur = q.last_v && (q.last_i == q.widx);
    assign data_ack = (q.st == ST_DATA) && (q.cnt == '0) && (q.tim.aa || !bus_ta_n);
    assign hold_len = hold_of(q.tim, q.we);

    always_comb begin
        d       = q;
        d.rsp_v = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (refuse) begin
                        d.rsp_v = 1'b1;
                        d.rsp_e = 1'b1;
                    end else begin
                        d.rsp_e = 1'b0;
                        d.we    = req_we;
                        d.addr  = req_addr;
                        d.wdata = req_wdata;
                        d.widx  = dec_idx;
                        d.tim   = dec_tim;
                        if (dec_tim.aset != 2'd0) begin
                            d.st  = ST_SETUP;
                            d.cnt = {4'd0, dec_tim.aset} - 6'd1;
                        end else begin
                            d.st  = ST_DATA;
                            d.cnt = wait_of(dec_tim, same_new);
                        end
                    end
                end
            end
            ST_SETUP: begin
                if (q.cnt == '0) begin
                    d.st  = ST_DATA;
                    d.cnt = wait_of(q.tim, same_cur);
                end else begin
                    d.cnt = q.cnt - 6'd1;
                end
            end
            ST_DATA: begin
                if (data_ack) begin
                    if (!q.we) d.rdata = bus_din;
                    d.last_v = 1'b1;
                    d.last_i = q.widx;
                    if (hold_len == 3'd0) begin
                        d.st    = ST_IDLE;
                        d.rsp_v = 1'b1;
                    end else begin
                        d.st  = ST_HOLD;
                        d.cnt = {3'd0, hold_len} - 6'd1;
                    end
                end else if (q.cnt != '0) begin
                    d.cnt = q.cnt - 6'd1;
                end
            end
            ST_HOLD: begin
                if (q.cnt == '0) begin
                    d.st    = ST_IDLE;
                    d.rsp_v = 1'b1;
                end else begin
                    d.cnt = q.cnt - 6'd1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_valid = q.rsp_v;
    assign rsp_err   = q.rsp_e;
    assign rsp_rdata = q.rdata;
    assign bus_addr  = q.addr;
    assign bus_aoe   = (q.st != ST_IDLE);
    assign bus_dout  = q.wdata;
    assign bus_oe_n  = !((q.st == ST_DATA) && !q.we);
    assign bus_we_n  = !((q.st == ST_DATA) && q.we);

    for (genvar i = 0; i < NWIN; i++) begin : g_cs
        assign bus_cs_n[i] = !((q.st == ST_DATA) && (q.widx == IW'(i)));
    end

endmodule

// File: rtl/ebus_csctl.sv
module ebus_csctl
    import ebus_pkg::*;
#(
    parameter int NWIN = 6,
    parameter int AW   = 32,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NWIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IW-1:0]     cfg_win,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_we,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DW-1:0]     rsp_rdata,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_aoe,
    output logic [DW-1:0]     bus_dout,
    input  logic [DW-1:0]     bus_din,
    output logic [NWIN-1:0]   bus_cs_n,
    output logic              bus_oe_n,
    output logic              bus_we_n,
    input  logic              bus_ta_n
);

    win_cfg_t [NWIN-1:0] win_cfg;
    logic                dec_hit;
    logic [IW-1:0]       dec_idx;
    logic                dec_wprot;
    tim_t                dec_tim;

    ebus_regs #(.NWIN(NWIN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_win   (cfg_win),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .win_cfg   (win_cfg)
    );

    ebus_decode #(.NWIN(NWIN)) u_dec (
        .win_cfg   (win_cfg),
        .addr_hi   (req_addr[AW-1 -: CMP_W]),
        .hit       (dec_hit),
        .hit_idx   (dec_idx),
        .hit_wprot (dec_wprot),
        .hit_tim   (dec_tim)
    );

    ebus_seq #(.NWIN(NWIN), .AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_we    (req_we),
        .req_wdata (req_wdata),
        .dec_hit   (dec_hit),
        .dec_idx   (dec_idx),
        .dec_wprot (dec_wprot),
        .dec_tim   (dec_tim),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .bus_addr  (bus_addr),
        .bus_aoe   (bus_aoe),
        .bus_dout  (bus_dout),
        .bus_din   (bus_din),
        .bus_cs_n  (bus_cs_n),
        .bus_oe_n  (bus_oe_n),
        .bus_we_n  (bus_we_n),
        .bus_ta_n  (bus_ta_n)
    );

endmodule

// File: rtl/ebus_csctl_chk.sv
module ebus_csctl_chk #(
    parameter int NWIN = 6,
    parameter int AW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_err,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_aoe,
    input logic [NWIN-1:0] bus_cs_n,
    input logic            bus_oe_n,
    input logic            bus_we_n
);

    AST_ONE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n)); // R3

    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_oe_n && !bus_we_n)); // R6

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe_n || !bus_we_n) |-> (bus_cs_n != '1)); // R6

    AST_CS_HAS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs_n != '1) |-> bus_aoe); // R5

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_aoe && $past(bus_aoe)) |-> $stable(bus_addr)); // R5

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_aoe |-> !req_ready); // R11

    AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (!bus_aoe && bus_cs_n == '1)); // R4

endmodule

bind ebus_csctl ebus_csctl_chk #(.NWIN(NWIN), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .bus_addr  (bus_addr),
    .bus_aoe   (bus_aoe),
    .bus_cs_n  (bus_cs_n),
    .bus_oe_n  (bus_oe_n),
    .bus_we_n  (bus_we_n)
);

// File: tb/sim_ebus_csctl.sv
`timescale 1ns/1ps
module sim_ebus_csctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_win = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [31:0] bus_din = '0;
    logic        bus_ta_n = 1'b1;
    logic        req_ready, rsp_valid, rsp_err, bus_aoe, bus_oe_n, bus_we_n;
    logic [31:0] rsp_rdata, bus_addr, bus_dout;
    logic [5:0]  bus_cs_n;

    int total = 0;
    int bad = 0;
    int g_setup, g_data, g_hold, g_cs, g_err, g_addr_bad, g_strobe_bad, g_ready_bad, g_pulse_bad;
    logic [31:0] g_rdata;

    always #2.5 clk = ~clk;

    ebus_csctl u0 (.*);

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_mask(input logic [15:0] m, input logic wp, input logic v);
        return {m, 7'd0, wp, 7'd0, v};
    endfunction

    function automatic logic [31:0] mk_ctrl(input logic [1:0] aset, input logic [1:0] rdah,
        input logic [1:0] wrah, input logic [5:0] ws, input logic aa, input logic swsen,
        input logic [5:0] sws);
        return {sws, 2'b00, swsen, 1'b0, aset, rdah, wrah, ws, 1'b0, aa, 8'd0};
    endfunction

    task automatic cfg_write(input logic [2:0] w, input logic [1:0] s, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = w; cfg_sel = s; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_win(input logic [2:0] w, input logic [15:0] base, input logic [31:0] mask,
        input logic [31:0] ctrl);
        cfg_write(w, 2'd0, {base, 16'd0});
        cfg_write(w, 2'd1, mask);
        cfg_write(w, 2'd2, ctrl);
    endtask

    // one request; phases are counted at the bus pins, one sample per cycle at negedge
    task automatic run_txn(input logic [31:0] a, input logic w, input logic [31:0] wd,
        input logic [31:0] din, input int ta_at);
        g_setup = 0; g_data = 0; g_hold = 0; g_cs = -1; g_err = -1;
        g_addr_bad = 0; g_strobe_bad = 0; g_ready_bad = 0; g_pulse_bad = 0;
        @(negedge clk);
        if (!req_ready) g_ready_bad++;
        req_valid = 1'b1; req_addr = a; req_we = w; req_wdata = wd; bus_din = din;
        bus_ta_n = (ta_at == 0) ? 1'b0 : 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (rsp_valid) begin
                g_err = rsp_err;
                g_rdata = rsp_rdata;
                break;
            end
            if (req_ready) g_ready_bad++;
            if (bus_aoe && bus_addr !== a) g_addr_bad++;
            if (bus_cs_n != 6'h3f) begin
                g_data++;
                for (int k = 0; k < 6; k++) if (!bus_cs_n[k]) g_cs = k;
                if (w) begin
                    if (bus_we_n !== 1'b0 || bus_oe_n !== 1'b1 || bus_dout !== wd) g_strobe_bad++;
                end else begin
                    if (bus_oe_n !== 1'b0 || bus_we_n !== 1'b1) g_strobe_bad++;
                end
                if (ta_at > 0 && g_data == ta_at) bus_ta_n = 1'b0;
            end else if (bus_aoe) begin
                if (g_data == 0) g_setup++;
                else             g_hold++;
            end
            @(negedge clk);
        end
        bus_ta_n = 1'b1;
        @(negedge clk);
        if (rsp_valid) g_pulse_bad++;
    endtask

    task automatic expect_txn(input string tag, input int es, input int ed, input int eh,
        input int ecs, input int eerr);
        chk({tag, " setup cycles"}, g_setup, es);
        chk({tag, " data cycles"}, g_data, ed);
        chk({tag, " hold cycles"}, g_hold, eh);
        chk({tag, " chip select"}, g_cs, ecs);
        chk({tag, " error flag"}, g_err, eerr);
        chk({tag, " R5 address"}, g_addr_bad, 0);
        chk({tag, " R6 strobes"}, g_strobe_bad, 0);
        chk({tag, " R11 ready low while busy"}, g_ready_bad, 0);
        chk({tag, " R11 single pulse"}, g_pulse_bad, 0);
    endtask

    task automatic t_reset();
        chk("R1 cs_n idle", bus_cs_n, 6'h3f);
        chk("R1 oe_n idle", bus_oe_n, 1);
        chk("R1 we_n idle", bus_we_n, 1);
        chk("R1 aoe low", bus_aoe, 0);
        chk("R1 ready high", req_ready, 1);
        chk("R1 no response", rsp_valid, 0);
        run_txn(32'h1000_0000, 1'b0, 0, 0, -1);
        expect_txn("R1 unprogrammed", 0, 0, 0, -1, 1);
    endtask

    task automatic t_basic_timing();
        set_win(3'd0, 16'h1000, mk_mask(16'h000F, 1'b0, 1'b1), mk_ctrl(2, 1, 2, 3, 1'b1, 1'b0, 0));
        run_txn(32'h1003_0040, 1'b0, 0, 32'hA5A5_0001, -1);
        expect_txn("R5 R6 R10 read w0", 2, 4, 1, 0, 0);
        chk("R6 read data auto ack", g_rdata, 32'hA5A5_0001);
        run_txn(32'h1005_0000, 1'b1, 32'hDEAD_BEEF, 0, -1);
        expect_txn("R9 write w0", 2, 4, 3, 0, 0);
    endtask

    task automatic t_cfg_ignored();
        cfg_write(3'd0, 2'd3, 32'hFFFF_FFFF);
        cfg_write(3'd7, 2'd0, 32'h7000_0000);
        cfg_write(3'd7, 2'd1, mk_mask(16'h0000, 1'b0, 1'b1));
        run_txn(32'h1000_0000, 1'b0, 0, 32'h1234, -1);
        expect_txn("R2 sel3 ignored", 2, 4, 1, 0, 0);
        run_txn(32'h7000_0000, 1'b0, 0, 0, -1);
        expect_txn("R2 window7 ignored", 0, 0, 0, -1, 1);
    endtask

    task automatic t_priority_ext_ack();
        set_win(3'd1, 16'h2000, mk_mask(16'h01FF, 1'b0, 1'b1), mk_ctrl(0, 0, 0, 0, 1'b1, 1'b0, 0));
        set_win(3'd3, 16'h2100, mk_mask(16'h0000, 1'b0, 1'b1), mk_ctrl(0, 0, 0, 1, 1'b0, 1'b0, 0));
        run_txn(32'h2100_0004, 1'b0, 0, 32'h55, -1);
        expect_txn("R3 lowest wins R10 aa hold0", 0, 1, 0, 1, 0);
        cfg_write(3'd1, 2'd1, mk_mask(16'h01FF, 1'b0, 1'b0));
        run_txn(32'h2100_0004, 1'b0, 0, 32'hC0DE_0001, 0);
        expect_txn("R3 invalid skipped R7 R10", 0, 2, 1, 3, 0);
        chk("R7 captured data", g_rdata, 32'hC0DE_0001);
        run_txn(32'h2100_0008, 1'b0, 0, 32'hC0DE_0002, 5);
        expect_txn("R7 late ack", 0, 5, 1, 3, 0);
        chk("R7 captured late data", g_rdata, 32'hC0DE_0002);
        run_txn(32'h2100_000C, 1'b0, 0, 32'hC0DE_0003, 1);
        expect_txn("R7 early ack waits count", 0, 2, 1, 3, 0);
    endtask

    task automatic t_protect();
        set_win(3'd2, 16'h3000, mk_mask(16'h0000, 1'b1, 1'b1), mk_ctrl(0, 0, 0, 0, 1'b1, 1'b0, 0));
        run_txn(32'h3000_0010, 1'b1, 32'h1111, 0, -1);
        expect_txn("R4 protected write", 0, 0, 0, -1, 1);
        run_txn(32'h3000_0010, 1'b0, 0, 32'h2222, -1);
        expect_txn("R4 protected read", 0, 1, 0, 2, 0);
        run_txn(32'h7700_0000, 1'b0, 0, 0, -1);
        expect_txn("R4 no match", 0, 0, 0, -1, 1);
    endtask

    task automatic t_secondary();
        set_win(3'd4, 16'h4000, mk_mask(16'h0000, 1'b0, 1'b1), mk_ctrl(0, 0, 0, 0, 1'b1, 1'b1, 3));
        run_txn(32'h4000_0000, 1'b0, 0, 1, -1);
        expect_txn("R8 first access primary", 0, 1, 0, 4, 0);
        run_txn(32'h4000_0004, 1'b0, 0, 2, -1);
        expect_txn("R8 repeat secondary", 0, 4, 0, 4, 0);
        run_txn(32'h4000_0008, 1'b1, 32'hBEEF, 0, -1);
        expect_txn("R8 R9 repeat write", 0, 4, 1, 4, 0);
        run_txn(32'h3000_0000, 1'b0, 0, 3, -1);
        expect_txn("R8 other window", 0, 1, 0, 2, 0);
        run_txn(32'h4000_000C, 1'b0, 0, 4, -1);
        expect_txn("R8 back to primary", 0, 1, 0, 4, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_timing();
        t_cfg_ignored();
        t_priority_ext_ack();
        t_protect();
        t_secondary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule